// File: doc/BRIEF.md
# CPU Pin Control and Interrupt Conditioning Unit

This unit sits between the sequencer of a small 4-bit processor core and the package pins. Each clock the sequencer presents one cycle-kind code. The unit turns that code into registered active-low strobes and a 2-bit data-bus state code. It also tracks whether the core is halted or asleep and drives the stop and micro-sleep indications from that state.

It also conditions the two external interrupt request pins. Both are synchronised. The non-maskable request is captured on a falling edge and held until the core's response cycle takes it. The maskable request is reported while its pin stays low and the interrupt-enable flag is set. During a response cycle the unit drives the acknowledge outputs. The non-maskable request wins when both are pending.

Cycle-kind codes: 0 idle, 1 instruction fetch, 2 nibble read, 3 nibble write, 4 stack-word read, 5 stack-word write, 6 vector read, 7 halt, 8 sleep, 9 interrupt response. Codes 10 to 15 act as idle.

Top module: `cpu_pin_ctl`

## Requirements
- R1: One cycle after a code is sampled, `bus_stat` is 11 for codes 2 and 4, 10 for codes 3 and 5, 01 for code 6, and 00 for every other code.
- R2: `rd_n` is low one cycle after code 2 or 4 and high otherwise. `wr_n` is low one cycle after code 3 or 5 and high otherwise. The two are never low together.
- R3: `vec_rd_n` is low one cycle after code 6 and high otherwise. A vector read leaves `rd_n` high.
- R4: `wide_n` is low one cycle after code 4 or 5 only.
- R5: `fetch_n` is low one cycle after code 1 only.
- R6: A falling edge on `nmi_n` sets `nmi_pend` whatever the flag is. A pin that stays low without a new falling edge does not set it again after it has been cleared.
- R7: `int_pend` is high while `irq_n` is low and `int_flag` is 1, or while `nmi_pend` is set. A low `irq_n` with `int_flag` at 0 leaves it low.
- R8: One cycle after code 9, `int_ack_n` is low. `nmi_ack_n` is also low when a non-maskable request was latched, and that request has priority over a maskable one. The latched request is cleared by that same response.
- R9: After code 7, `stop_n` goes low and `sleep_n` stays high. After code 8, both go low. Any pending interrupt brings both back high.
- R10: While `rst_n` is low, `stop_n` is low, all strobes are high, `bus_stat` is 00 and `nmi_pend` is cleared.
- R11: `iflag_n` is the inverse of `int_flag`, delayed by one register.
- R12: While the core is stopped, cycle codes have no effect: all strobes stay high and `bus_stat` stays 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| cyc_kind | input | 4 | Cycle-kind code from the sequencer |
| int_flag | input | 1 | Interrupt-enable flag bit |
| nmi_n | input | 1 | Non-maskable request pin, falling-edge |
| irq_n | input | 1 | Maskable request pin, low-level |
| fetch_n | output | 1 | Instruction fetch strobe |
| rd_n | output | 1 | Data read strobe |
| wr_n | output | 1 | Data write strobe |
| vec_rd_n | output | 1 | Interrupt vector read strobe |
| wide_n | output | 1 | Stack-word (16-bit) access indication |
| bus_stat | output | 2 | Data-bus state code |
| int_ack_n | output | 1 | Acknowledge for either interrupt type |
| nmi_ack_n | output | 1 | Acknowledge for non-maskable response only |
| stop_n | output | 1 | Core stopped or in reset |
| sleep_n | output | 1 | Micro-sleep indication |
| iflag_n | output | 1 | Inverted interrupt flag |
| int_pend | output | 1 | An interrupt is pending (to the core) |
| nmi_pend | output | 1 | Non-maskable request latched (to the core) |

## Verification
The bench builds the unit with two synchroniser stages and a 4-bit code field. The code field is small enough to sweep all sixteen cycle-kind values, the unused ones included, in both the running and the stopped state. The short synchroniser keeps the latency of each request pin to a few cycles. That lets the bench walk through every mix of edge, level and flag in each response and wake-up case, including priority between the two interrupt types at the same moment.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  localparam int KIND_W = 4;

  typedef enum logic [KIND_W-1:0] {
    CK_IDLE  = 4'd0,
    CK_FETCH = 4'd1,
    CK_RD4   = 4'd2,
    CK_WR4   = 4'd3,
    CK_RD16  = 4'd4,
    CK_WR16  = 4'd5,
    CK_VEC   = 4'd6,
    CK_HALT  = 4'd7,
    CK_SLEEP = 4'd8,
    CK_RESP  = 4'd9
  } cyc_kind_e;

  localparam logic [1:0] BS_IDLE = 2'b00;
  localparam logic [1:0] BS_VEC  = 2'b01;
  localparam logic [1:0] BS_WR   = 2'b10;
  localparam logic [1:0] BS_RD   = 2'b11;

  typedef struct packed {
    logic       fetch_n;
    logic       rd_n;
    logic       wr_n;
    logic       vec_n;
    logic       wide_n;
    logic [1:0] stat;
    logic       ack_n;
    logic       nmi_ack_n;
  } pin_s;

  localparam pin_s PIN_IDLE = '{fetch_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1,
                                vec_n: 1'b1, wide_n: 1'b1, stat: BS_IDLE,
                                ack_n: 1'b1, nmi_ack_n: 1'b1};
endpackage

// File: rtl/cpc_sync.sv
module cpc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= RST_VAL;
        else        chain_q[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= RST_VAL;
        else        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/cpc_irq_cond.sv
module cpc_irq_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_s_n,
  input  logic irq_s_n,
  input  logic flag,
  input  logic take_resp,
  output logic nmi_pend,
  output logic irq_pend
);
  logic nmi_prev_q, nmi_lat_q;
  logic nmi_prev_d, nmi_lat_d;
  logic nmi_fall;

  always_comb begin
    nmi_fall   = nmi_prev_q & ~nmi_s_n;
    nmi_prev_d = nmi_s_n;
    nmi_lat_d  = nmi_lat_q;
    if (take_resp && nmi_lat_q) nmi_lat_d = 1'b0;
    if (nmi_fall)               nmi_lat_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_prev_q <= 1'b1;
      nmi_lat_q  <= 1'b0;
    end else begin
      nmi_prev_q <= nmi_prev_d;
      nmi_lat_q  <= nmi_lat_d;
    end
  end

  assign nmi_pend = nmi_lat_q;
  assign irq_pend = ~irq_s_n & flag;
endmodule

// File: rtl/cpc_power.sv
module cpc_power
  import cpc_pkg::*;
#(
  parameter int KW = KIND_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [KW-1:0] kind,
  input  logic          wake,
  output logic          stopped,
  output logic          sleeping
);
  logic stop_q, slp_q, stop_d, slp_d, upd_en;

  always_comb begin
    stop_d = stop_q;
    slp_d  = slp_q;
    upd_en = 1'b0;
    if (stop_q) begin
      if (wake) begin
        stop_d = 1'b0;
        slp_d  = 1'b0;
        upd_en = 1'b1;
      end
    end else if (kind == CK_HALT) begin
      stop_d = 1'b1;
      upd_en = 1'b1;
    end else if (kind == CK_SLEEP) begin
      stop_d = 1'b1;
      slp_d  = 1'b1;
      upd_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
      slp_q  <= 1'b0;
    end else if (upd_en) begin
      stop_q <= stop_d;
      slp_q  <= slp_d;
    end
  end

  assign stopped  = stop_q;
  assign sleeping = slp_q;
endmodule

// File: rtl/cpc_bus_dec.sv
module cpc_bus_dec
  import cpc_pkg::*;
#(
  parameter int KW = KIND_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [KW-1:0] kind,
  input  logic          stopped,
  input  logic          nmi_sel,
  output pin_s          pins
);
  pin_s pins_d, pins_q;

  always_comb begin
    pins_d = PIN_IDLE;
    if (!stopped) begin
      case (kind)
        CK_FETCH: pins_d.fetch_n = 1'b0;
        CK_RD4: begin
          pins_d.rd_n = 1'b0;
          pins_d.stat = BS_RD;
        end
        CK_WR4: begin
          pins_d.wr_n = 1'b0;
          pins_d.stat = BS_WR;
        end
        CK_RD16: begin
          pins_d.rd_n   = 1'b0;
          pins_d.wide_n = 1'b0;
          pins_d.stat   = BS_RD;
        end
        CK_WR16: begin
          pins_d.wr_n   = 1'b0;
          pins_d.wide_n = 1'b0;
          pins_d.stat   = BS_WR;
        end
        CK_VEC: begin
          pins_d.vec_n = 1'b0;
          pins_d.stat  = BS_VEC;
        end
        CK_RESP: begin
          pins_d.ack_n     = 1'b0;
          pins_d.nmi_ack_n = ~nmi_sel;
        end
        default: pins_d = PIN_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pins_q <= PIN_IDLE;
    else        pins_q <= pins_d;
  end

  assign pins = pins_q;
endmodule

// File: rtl/cpu_pin_ctl.sv
module cpu_pin_ctl
  import cpc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [KIND_W-1:0] cyc_kind,
  input  logic              int_flag,
  input  logic              nmi_n,
  input  logic              irq_n,
  output logic              fetch_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              vec_rd_n,
  output logic              wide_n,
  output logic [1:0]        bus_stat,
  output logic              int_ack_n,
  output logic              nmi_ack_n,
  output logic              stop_n,
  output logic              sleep_n,
  output logic              iflag_n,
  output logic              int_pend,
  output logic              nmi_pend
);
  logic rst_s_n, nmi_s_n, irq_s_n, irq_p, nmi_p;
  logic stopped, sleeping, take_resp, iflag_q;
  pin_s pins;

  cpc_sync #(.STAGES(RST_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .din(1'b1), .dout(rst_s_n));

  cpc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_nmi_sync (
    .clk(clk), .rst_n(rst_s_n), .din(nmi_n), .dout(nmi_s_n));

  cpc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_irq_sync (
    .clk(clk), .rst_n(rst_s_n), .din(irq_n), .dout(irq_s_n));

  assign take_resp = (cyc_kind == CK_RESP) && !stopped;

  cpc_irq_cond u_irq (
    .clk(clk), .rst_n(rst_s_n), .nmi_s_n(nmi_s_n), .irq_s_n(irq_s_n),
    .flag(int_flag), .take_resp(take_resp),
    .nmi_pend(nmi_p), .irq_pend(irq_p));

  cpc_power #(.KW(KIND_W)) u_pwr (
    .clk(clk), .rst_n(rst_s_n), .kind(cyc_kind), .wake(nmi_p | irq_p),
    .stopped(stopped), .sleeping(sleeping));

  cpc_bus_dec #(.KW(KIND_W)) u_dec (
    .clk(clk), .rst_n(rst_s_n), .kind(cyc_kind), .stopped(stopped),
    .nmi_sel(nmi_p), .pins(pins));

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) iflag_q <= 1'b1;
    else          iflag_q <= ~int_flag;
  end

  assign fetch_n   = pins.fetch_n;
  assign rd_n      = pins.rd_n;
  assign wr_n      = pins.wr_n;
  assign vec_rd_n  = pins.vec_n;
  assign wide_n    = pins.wide_n;
  assign bus_stat  = pins.stat;
  assign int_ack_n = pins.ack_n;
  assign nmi_ack_n = pins.nmi_ack_n;
  assign stop_n    = rst_s_n & ~stopped;
  assign sleep_n   = ~sleeping;
  assign iflag_n   = iflag_q;
  assign int_pend  = nmi_p | irq_p;
  assign nmi_pend  = nmi_p;
endmodule

// File: rtl/cpu_pin_ctl_chk.sv
module cpu_pin_ctl_chk
  import cpc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [KIND_W-1:0] cyc_kind,
  input logic              fetch_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic              vec_rd_n,
  input logic              wide_n,
  input logic [1:0]        bus_stat,
  input logic              int_ack_n,
  input logic              nmi_ack_n,
  input logic              stop_n,
  input logic              sleep_n,
  input logic              nmi_pend
);
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n)); // R2
  AST_RD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> bus_stat == BS_RD); // R1
  AST_VEC_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_rd_n |-> (bus_stat == BS_VEC && rd_n)); // R3
  AST_WIDE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_n |-> (!rd_n || !wr_n)); // R4
  AST_FETCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_n |-> bus_stat == BS_IDLE); // R5
  AST_NMI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend && cyc_kind != CK_RESP) |=> nmi_pend); // R6
  AST_NMI_ACK_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    !nmi_ack_n |-> !int_ack_n); // R8
  AST_SLEEP_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |-> !stop_n); // R9
  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_n |-> (rd_n && wr_n && vec_rd_n && fetch_n && bus_stat == BS_IDLE)); // R12
endmodule

bind cpu_pin_ctl cpu_pin_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_kind(cyc_kind), .fetch_n(fetch_n),
  .rd_n(rd_n), .wr_n(wr_n), .vec_rd_n(vec_rd_n), .wide_n(wide_n),
  .bus_stat(bus_stat), .int_ack_n(int_ack_n), .nmi_ack_n(nmi_ack_n),
  .stop_n(stop_n), .sleep_n(sleep_n), .nmi_pend(nmi_pend));

// File: tb/cpu_pin_ctl_test.sv
module cpu_pin_ctl_test;
  localparam int SYNC = 2;
  localparam int SETTLE = SYNC + 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [3:0] cyc_kind;
  logic int_flag, nmi_n, irq_n;
  logic fetch_n, rd_n, wr_n, vec_rd_n, wide_n, int_ack_n, nmi_ack_n;
  logic stop_n, sleep_n, iflag_n, int_pend, nmi_pend;
  logic [1:0] bus_stat;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cpu_pin_ctl #(.SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst_n(rst_n), .cyc_kind(cyc_kind), .int_flag(int_flag),
    .nmi_n(nmi_n), .irq_n(irq_n), .fetch_n(fetch_n), .rd_n(rd_n),
    .wr_n(wr_n), .vec_rd_n(vec_rd_n), .wide_n(wide_n), .bus_stat(bus_stat),
    .int_ack_n(int_ack_n), .nmi_ack_n(nmi_ack_n), .stop_n(stop_n),
    .sleep_n(sleep_n), .iflag_n(iflag_n), .int_pend(int_pend),
    .nmi_pend(nmi_pend));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // packed {fetch,rd,wr,vec,wide,stat[1:0]}
  function automatic logic [6:0] expect_pins(input int k);
    logic [6:0] e;
    e = 7'b1111100;
    if (k == 1) e[6] = 1'b0;
    if (k == 2 || k == 4) begin e[5] = 1'b0; e[1:0] = 2'd3; end
    if (k == 3 || k == 5) begin e[4] = 1'b0; e[1:0] = 2'd2; end
    if (k == 6) begin e[3] = 1'b0; e[1:0] = 2'd1; end
    if (k == 4 || k == 5) e[2] = 1'b0;
    return e;
  endfunction

  function automatic logic [6:0] got_pins();
    return {fetch_n, rd_n, wr_n, vec_rd_n, wide_n, bus_stat};
  endfunction

  initial begin
    rst_n = 1'b0; cyc_kind = 4'd0; int_flag = 1'b0; nmi_n = 1'b1; irq_n = 1'b1;
    cyc(3);
    // R10 reset state
    chk(stop_n == 1'b0, "R10 stop_n in reset", stop_n, 0);
    chk(got_pins() == 7'b1111100, "R10 pins in reset", got_pins(), 7'b1111100);
    chk(nmi_pend == 1'b0, "R10 nmi_pend in reset", nmi_pend, 0);
    rst_n = 1'b1;
    cyc(4);
    chk(stop_n == 1'b1, "R10 stop_n after release", stop_n, 1);

    // R1..R5 sweep every code while running (halt/sleep handled below)
    for (int k = 0; k < 16; k++) begin
      if (k == 7 || k == 8) continue;
      cyc_kind = 4'(k);
      cyc(1);
      cyc_kind = 4'd0;
      chk(got_pins() == expect_pins(k), "R1 R2 R3 R4 R5 code sweep", got_pins(), expect_pins(k));
      chk(int_ack_n == (k == 9 ? 1'b0 : 1'b1), "R8 ack per code", int_ack_n, k == 9 ? 0 : 1);
      chk(nmi_ack_n == 1'b1, "R8 no nmi ack without latch", nmi_ack_n, 1);
      cyc(1);
      chk(got_pins() == 7'b1111100, "R1 return to idle", got_pins(), 7'b1111100);
    end

    // R11 flag inversion
    for (int f = 0; f < 2; f++) begin
      int_flag = f[0];
      cyc(2);
      chk(iflag_n == ~f[0], "R11 iflag_n", iflag_n, int'(~f[0]));
    end

    // R9/R12 halt and sleep, swept against every code while stopped
    for (int m = 7; m <= 8; m++) begin
      int_flag = 1'b1;
      cyc_kind = 4'(m);
      cyc(1);
      cyc_kind = 4'd0;
      chk(stop_n == 1'b0, "R9 stop_n after stop code", stop_n, 0);
      chk(sleep_n == (m == 8 ? 1'b0 : 1'b1), "R9 sleep_n", sleep_n, m == 8 ? 0 : 1);
      for (int k = 0; k < 16; k++) begin
        cyc_kind = 4'(k);
        cyc(1);
        chk(got_pins() == 7'b1111100 && int_ack_n, "R12 ignored while stopped", got_pins(), 7'b1111100);
      end
      cyc_kind = 4'd0;
      chk(stop_n == 1'b0, "R12 still stopped", stop_n, 0);
      irq_n = 1'b0;
      cyc(SETTLE);
      chk(stop_n == 1'b1 && sleep_n == 1'b1, "R9 wake on pending irq", {stop_n, sleep_n}, 3);
      irq_n = 1'b1;
      cyc(SETTLE);
    end

    // R7 maskable level and flag
    int_flag = 1'b0; irq_n = 1'b0;
    cyc(SETTLE);
    chk(int_pend == 1'b0, "R7 masked by flag", int_pend, 0);
    int_flag = 1'b1;
    cyc(1);
    chk(int_pend == 1'b1, "R7 low level with flag", int_pend, 1);
    irq_n = 1'b1;
    cyc(SETTLE);
    chk(int_pend == 1'b0, "R7 released", int_pend, 0);

    // R6 edge capture ignores flag
    int_flag = 1'b0; nmi_n = 1'b0;
    cyc(SETTLE);
    chk(nmi_pend == 1'b1, "R6 falling edge latched", nmi_pend, 1);
    chk(int_pend == 1'b1, "R7 nmi counts as pending", int_pend, 1);

    // R8 priority: both pending
    int_flag = 1'b1; irq_n = 1'b0;
    cyc(SETTLE);
    cyc_kind = 4'd9;
    cyc(1);
    cyc_kind = 4'd0;
    chk(int_ack_n == 1'b0 && nmi_ack_n == 1'b0, "R8 nmi response wins", {int_ack_n, nmi_ack_n}, 0);
    chk(nmi_pend == 1'b0, "R8 latch cleared by response", nmi_pend, 1'b0);
    cyc(SETTLE);
    chk(nmi_pend == 1'b0, "R6 held low pin no relatch", nmi_pend, 0);
    cyc_kind = 4'd9;
    cyc(1);
    cyc_kind = 4'd0;
    chk(int_ack_n == 1'b0 && nmi_ack_n == 1'b1, "R8 maskable response", {int_ack_n, nmi_ack_n}, 1);
    irq_n = 1'b1; nmi_n = 1'b1;
    cyc(SETTLE);

    // R10 reset clears latch
    nmi_n = 1'b0;
    cyc(SETTLE);
    chk(nmi_pend == 1'b1, "R6 second edge latched", nmi_pend, 1);
    rst_n = 1'b0;
    cyc(1);
    chk(nmi_pend == 1'b0 && stop_n == 1'b0, "R10 reset clears latch", {nmi_pend, stop_n}, 0);
    rst_n = 1'b1;
    cyc(4);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule